// File: doc/BRIEF.md
# Parallel Top-Three Track Selector

The block takes six candidate tracks, each carrying a quality number and an identifier. It returns the three best distinct candidates as three output slots. Each slot holds a quality, the input position it came from, and a valid flag. A higher quality is better. The identifier names the stubs a track was built from, so two candidates with the same nonzero identifier are the same track, and only one of them may be reported.

The selection takes two logic levels and no sequential merge passes:

- **Compare.** Every one of the 15 unordered input pairs has its own greater-or-equal comparator. The comparator outputs form a win vector.
- **Disqualify.** Identifier comparators and an empty-input test mark candidates that must not be reported. The win vector is then rewritten so that a marked candidate loses every comparison it takes part in.
- **Decode.** Each candidate's rank is the number of comparisons it loses. The candidates at ranks 0, 1 and 2 fill the three slots.

An optional output register, selected by a parameter and on by default, holds the results for one clock.

Top module: `top3_select`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered outputs clear at that edge. All of `slot_vld` goes low, and every `slot_q` and `slot_pos` field goes to zero, whatever the inputs are.
- R2: With the output register enabled, a result appears at the rising edge after the inputs are sampled. Between edges, the outputs keep the previous result.
- R3: The valid slots carry strictly the best surviving candidates, with slot 0 the best. The slot qualities do not increase from slot 0 to slot 2.
- R4: When two surviving candidates have equal quality, the one at the lower input position takes the earlier slot.
- R5: An input whose quality is zero is empty and never appears in a valid slot.
- R6: When two candidates share a nonzero identifier, the one with the lower quality is excluded, so no two valid slots come from the same nonzero identifier.
- R7: When two candidates share a nonzero identifier and have equal quality, the one at the higher input position is excluded.
- R8: An identifier of zero matches nothing, so candidates that all have identifier zero are ranked only by quality.
- R9: When fewer than three candidates survive, the trailing slots have `slot_vld` low and drive quality 0 and position 0. A slot is never valid while an earlier slot is invalid.
- R10: Input k, for k from 0 to 5, occupies `q_in[k*QW +: QW]` and `id_in[k*IW +: IW]`. Slot s occupies `slot_q[s*QW +: QW]` and `slot_pos[s*3 +: 3]`, and its position field holds the binary value k of the input it reports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| q_in | input | N*QW (36) | Qualities of the six candidates; 0 means empty |
| id_in | input | N*IW (48) | Identifiers of the six candidates; 0 means no identifier |
| slot_q | output | NSLOT*QW (18) | Qualities of the selected candidates, slot 0 best |
| slot_pos | output | NSLOT*PW (9) | Input position of each selected candidate |
| slot_vld | output | NSLOT (3) | Valid flag for each slot |

## Verification
Directed patterns separate the different causes of a candidate's placement:

- **Distinct qualities with unique identifiers** show that the plain ordering and the position encoding are correct.
- **Equal-quality groups** show that the lower position wins ties.
- **Shared identifiers**, with different qualities and with equal qualities, show that the lower-quality candidate, or on equal quality the higher-position one, is the one removed.
- **Zero identifiers** show that zero never counts as a match.
- **Mostly empty inputs, and a single identifier shared by all candidates,** leave fewer than three survivors and exercise the cleared trailing slots.
- **Sampling between edges and a reset applied mid-run** separate the one-cycle latency from the reset behaviour.

// File: rtl/top3_pkg.sv
package top3_pkg;
    // Linear index of unordered pair (i,j), i<j, in the order
    // (0,1),(0,2)..(0,n-1),(1,2).. ; the decoders rely on this order.
    function automatic int pair_idx(input int i, input int j, input int n);
        return i * n - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction
endpackage

// File: rtl/top3_pair_cmp.sv
module top3_pair_cmp #(
    parameter int N  = 6,
    parameter int QW = 6,
    localparam int NP = N * (N - 1) / 2
) (
    input  logic [N*QW-1:0] q,
    output logic [NP-1:0]   win
);
    // one comparator per pair: bit is 1 when the lower-indexed side is >=
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = i + 1; j < N; j++) begin : g_col
            localparam int P = top3_pkg::pair_idx(i, j, N);
            assign win[P] = (q[i*QW +: QW] >= q[j*QW +: QW]);
        end
    end
endmodule

// File: rtl/top3_dup_filter.sv
module top3_dup_filter #(
    parameter int N  = 6,
    parameter int QW = 6,
    parameter int IW = 8,
    localparam int NP = N * (N - 1) / 2
) (
    input  logic [N*QW-1:0] q,
    input  logic [N*IW-1:0] id,
    input  logic [NP-1:0]   win_raw,
    output logic [N-1:0]    kill,
    output logic [NP-1:0]   win_adj
);
    // a candidate is removed when empty or beaten by a same-id candidate
    always_comb begin
        for (int j = 0; j < N; j++) begin
            kill[j] = (q[j*QW +: QW] == '0);
            for (int i = 0; i < N; i++) begin
                if (i != j) begin
                    logic same;
                    logic beats;
                    same  = (id[i*IW +: IW] == id[j*IW +: IW]) && (id[j*IW +: IW] != '0);
                    beats = (i < j) ? win_raw[top3_pkg::pair_idx(i, j, N)]
                                    : !win_raw[top3_pkg::pair_idx(j, i, N)];
                    if (same && beats) kill[j] = 1'b1;
                end
            end
        end
    end

    // removed candidates lose every comparison against a survivor
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = i + 1; j < N; j++) begin : g_col
            localparam int P = top3_pkg::pair_idx(i, j, N);
            always_comb begin
                unique case ({kill[i], kill[j]})
                    2'b10:   win_adj[P] = 1'b0;
                    2'b01:   win_adj[P] = 1'b1;
                    default: win_adj[P] = win_raw[P];
                endcase
            end
        end
    end
endmodule

// File: rtl/top3_rank_decode.sv
module top3_rank_decode #(
    parameter int N     = 6,
    parameter int QW    = 6,
    parameter int NSLOT = 3,
    localparam int NP = N * (N - 1) / 2,
    localparam int PW = $clog2(N)
) (
    input  logic [N*QW-1:0]     q,
    input  logic [NP-1:0]       win,
    input  logic [N-1:0]        kill,
    output logic [NSLOT*QW-1:0] slot_q,
    output logic [NSLOT*PW-1:0] slot_pos,
    output logic [NSLOT-1:0]    slot_vld
);
    logic [PW-1:0] loss [N];

    always_comb begin
        for (int k = 0; k < N; k++) loss[k] = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (win[top3_pkg::pair_idx(i, j, N)]) loss[j] = loss[j] + PW'(1);
                else                                  loss[i] = loss[i] + PW'(1);
            end
        end
        slot_q   = '0;
        slot_pos = '0;
        slot_vld = '0;
        for (int r = 0; r < NSLOT; r++) begin
            for (int k = 0; k < N; k++) begin
                if (loss[k] == PW'(r) && !kill[k]) begin
                    slot_vld[r]          = 1'b1;
                    slot_q[r*QW +: QW]   = q[k*QW +: QW];
                    slot_pos[r*PW +: PW] = PW'(k);
                end
            end
        end
    end
endmodule

// File: rtl/top3_select.sv
module top3_select #(
    parameter int N       = 6,
    parameter int QW      = 6,
    parameter int IW      = 8,
    parameter int NSLOT   = 3,
    parameter bit REG_OUT = 1'b1,
    localparam int NP = N * (N - 1) / 2,
    localparam int PW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N*QW-1:0]     q_in,
    input  logic [N*IW-1:0]     id_in,
    output logic [NSLOT*QW-1:0] slot_q,
    output logic [NSLOT*PW-1:0] slot_pos,
    output logic [NSLOT-1:0]    slot_vld
);
    logic [NP-1:0]       win_raw;
    logic [NP-1:0]       win_adj;
    logic [N-1:0]        kill;
    logic [NSLOT*QW-1:0] nxt_q;
    logic [NSLOT*PW-1:0] nxt_pos;
    logic [NSLOT-1:0]    nxt_vld;

    top3_pair_cmp #(.N(N), .QW(QW)) u_cmp (
        .q   (q_in),
        .win (win_raw)
    );

    top3_dup_filter #(.N(N), .QW(QW), .IW(IW)) u_dup (
        .q       (q_in),
        .id      (id_in),
        .win_raw (win_raw),
        .kill    (kill),
        .win_adj (win_adj)
    );

    top3_rank_decode #(.N(N), .QW(QW), .NSLOT(NSLOT)) u_dec (
        .q        (q_in),
        .win      (win_adj),
        .kill     (kill),
        .slot_q   (nxt_q),
        .slot_pos (nxt_pos),
        .slot_vld (nxt_vld)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q   <= '0;
                slot_pos <= '0;
                slot_vld <= '0;
            end else begin
                slot_q   <= nxt_q;
                slot_pos <= nxt_pos;
                slot_vld <= nxt_vld;
            end
        end
    end else begin : g_comb
        assign slot_q   = nxt_q;
        assign slot_pos = nxt_pos;
        assign slot_vld = nxt_vld;
    end
endmodule

// File: rtl/top3_select_chk.sv
module top3_select_chk #(
    parameter int N       = 6,
    parameter int QW      = 6,
    parameter int IW      = 8,
    parameter int NSLOT   = 3,
    parameter bit REG_OUT = 1'b1,
    localparam int PW = $clog2(N)
) (
    input logic                clk,
    input logic                rst,
    input logic [N*QW-1:0]     q_in,
    input logic [N*IW-1:0]     id_in,
    input logic [NSLOT*QW-1:0] slot_q,
    input logic [NSLOT*PW-1:0] slot_pos,
    input logic [NSLOT-1:0]    slot_vld
);
    function automatic logic [QW-1:0] q_at(input logic [N*QW-1:0] v, input logic [PW-1:0] p);
        return v[p*QW +: QW];
    endfunction
    function automatic logic [IW-1:0] id_at(input logic [N*IW-1:0] v, input logic [PW-1:0] p);
        return v[p*IW +: IW];
    endfunction

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assert_empty_never_R5: assert property (@(posedge clk) disable iff (rst)
            slot_vld[s] |-> slot_q[s*QW +: QW] != '0);
        assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
            !slot_vld[s] |-> (slot_q[s*QW +: QW] == '0 && slot_pos[s*PW +: PW] == '0));
        if (s > 0) begin : g_prev
            assert_contig_R9: assert property (@(posedge clk) disable iff (rst)
                slot_vld[s] |-> slot_vld[s-1]);
            assert_desc_R3: assert property (@(posedge clk) disable iff (rst)
                slot_vld[s] |-> slot_q[(s-1)*QW +: QW] >= slot_q[s*QW +: QW]);
        end
        if (REG_OUT) begin : g_src
            assert_source_R10: assert property (@(posedge clk) disable iff (rst)
                slot_vld[s] |-> slot_q[s*QW +: QW] == q_at($past(q_in), slot_pos[s*PW +: PW]));
            for (genvar t = s + 1; t < NSLOT; t++) begin : g_pair
                assert_distinct_R6: assert property (@(posedge clk) disable iff (rst)
                    (slot_vld[s] && slot_vld[t]) |->
                    (id_at($past(id_in), slot_pos[s*PW +: PW]) == '0 ||
                     id_at($past(id_in), slot_pos[s*PW +: PW]) != id_at($past(id_in), slot_pos[t*PW +: PW])));
            end
        end
    end

    if (REG_OUT) begin : g_rst
        assert_reset_clear_R1: assert property (@(posedge clk)
            $past(rst) |-> (slot_vld == '0 && slot_q == '0 && slot_pos == '0));
    end
endmodule

bind top3_select top3_select_chk #(
    .N(N), .QW(QW), .IW(IW), .NSLOT(NSLOT), .REG_OUT(REG_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .q_in     (q_in),
    .id_in    (id_in),
    .slot_q   (slot_q),
    .slot_pos (slot_pos),
    .slot_vld (slot_vld)
);

// File: tb/tb_top3_select.sv
module tb_top3_select;
    localparam int N = 6, QW = 6, IW = 8, NS = 3, PW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*QW-1:0]   q_in = '0;
    logic [N*IW-1:0]   id_in = '0;
    logic [NS*QW-1:0]  slot_q;
    logic [NS*PW-1:0]  slot_pos;
    logic [NS-1:0]     slot_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    top3_select #(.N(N), .QW(QW), .IW(IW), .NSLOT(NS), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .q_in(q_in), .id_in(id_in),
        .slot_q(slot_q), .slot_pos(slot_pos), .slot_vld(slot_vld)
    );

    task automatic chk_slot(input int s, input bit v, input int q, input int p, input string req);
        logic          av;
        logic [QW-1:0] aq;
        logic [PW-1:0] ap;
        av = slot_vld[s];
        aq = slot_q[s*QW +: QW];
        ap = slot_pos[s*PW +: PW];
        checks++;
        if (av !== v || aq !== QW'(q) || ap !== PW'(p)) begin
            errors++;
            $display("FAIL %s slot%0d: got vld=%0b q=%0d pos=%0d, expected vld=%0b q=%0d pos=%0d",
                     req, s, av, aq, ap, v, q, p);
        end
    endtask

    // arguments list position 5 first, position 0 last
    task automatic apply(input logic [N*QW-1:0] q, input logic [N*IW-1:0] id);
        @(negedge clk);
        q_in  = q;
        id_in = id;
        @(negedge clk);
    endtask

    task automatic t_reset_R1;
        chk_slot(0, 0, 0, 0, "R1");
        chk_slot(1, 0, 0, 0, "R1");
        chk_slot(2, 0, 0, 0, "R1");
    endtask

    task automatic t_order_R3;
        apply({6'd2, 6'd8, 6'd3, 6'd10, 6'd1, 6'd5}, {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1});
        chk_slot(0, 1, 10, 2, "R3/R10");
        chk_slot(1, 1, 8, 4, "R3/R10");
        chk_slot(2, 1, 5, 0, "R3/R10");
    endtask

    task automatic t_latency_R2;
        @(negedge clk);
        q_in  = {6'd7, 6'd1, 6'd7, 6'd7, 6'd7, 6'd4};
        id_in = {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1};
        #2;
        chk_slot(0, 1, 10, 2, "R2 hold");
        @(negedge clk);
        chk_slot(0, 1, 7, 1, "R2 update");
    endtask

    task automatic t_ties_R4;
        apply({6'd7, 6'd1, 6'd7, 6'd7, 6'd7, 6'd4}, {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1});
        chk_slot(0, 1, 7, 1, "R4");
        chk_slot(1, 1, 7, 2, "R4");
        chk_slot(2, 1, 7, 3, "R4");
    endtask

    task automatic t_empty_R5;
        apply({6'd3, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0}, {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1});
        chk_slot(0, 1, 3, 5, "R5");
        chk_slot(1, 0, 0, 0, "R5/R9");
        chk_slot(2, 0, 0, 0, "R5/R9");
    endtask

    task automatic t_dup_R6;
        apply({6'd2, 6'd6, 6'd11, 6'd4, 6'd12, 6'd9}, {8'd5, 8'd4, 8'd2, 8'd3, 8'd2, 8'd1});
        chk_slot(0, 1, 12, 1, "R6");
        chk_slot(1, 1, 9, 0, "R6");
        chk_slot(2, 1, 6, 4, "R6");
    endtask

    task automatic t_dup_tie_R7;
        apply({6'd1, 6'd8, 6'd8, 6'd3, 6'd3, 6'd3}, {8'd2, 8'd6, 8'd5, 8'd9, 8'd7, 8'd7});
        chk_slot(0, 1, 8, 3, "R7");
        chk_slot(1, 1, 8, 4, "R7");
        chk_slot(2, 1, 3, 0, "R7");
    endtask

    task automatic t_zero_id_R8;
        apply({6'd1, 6'd1, 6'd1, 6'd5, 6'd5, 6'd5}, '0);
        chk_slot(0, 1, 5, 0, "R8");
        chk_slot(1, 1, 5, 1, "R8");
        chk_slot(2, 1, 5, 2, "R8");
    endtask

    task automatic t_one_id_R9;
        apply({6'd1, 6'd9, 6'd0, 6'd4, 6'd6, 6'd2}, {N{8'd3}});
        chk_slot(0, 1, 9, 4, "R9");
        chk_slot(1, 0, 0, 0, "R9");
        chk_slot(2, 0, 0, 0, "R9");
    endtask

    task automatic t_midrun_reset_R1;
        apply({6'd2, 6'd8, 6'd3, 6'd10, 6'd1, 6'd5}, {8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1});
        rst = 1'b1;
        @(negedge clk);
        chk_slot(0, 0, 0, 0, "R1 midrun");
        chk_slot(2, 0, 0, 0, "R1 midrun");
        rst = 1'b0;
        @(negedge clk);
        chk_slot(0, 1, 10, 2, "R1 release");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst = 1'b0;
        t_order_R3();
        t_latency_R2();
        t_ties_R4();
        t_empty_R5();
        t_dup_R6();
        t_dup_tie_R7();
        t_zero_id_R8();
        t_one_id_R9();
        t_midrun_reset_R1();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion within 2000 cycles");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule